// File: doc/BRIEF.md
# UART Receive FIFO Status and Interrupt Core

This block keeps the receive FIFO of one 16550-style serial channel and derives the eight-bit line status byte and the receive-data interrupt from it. The receiver shift register hands over each finished character with a one-cycle strobe. The strobe carries the character's eight data bits and its own parity, framing and break flags. These are stored together as one FIFO entry. The host pops the head character with a read strobe and acknowledges the status byte with a second strobe.

The transmit side has no storage here. The block takes the transmit FIFO occupancy and a shift-register-idle flag, and turns them into the two transmit status bits.

A two-bit selector chooses the receive trigger level. The trigger status flag, and the receive interrupt derived from it, track the FIFO count against that level in both directions, with no latching. Baud generation, serialization, modem lines and the register map are outside this block.

Top module: `uart_lsr_core`

## Requirements
- R1: Status bit 0 (data ready) reads 1 in the cycle after a character strobe is accepted. It stays 1 until the FIFO holds no character.
- R2: A character strobe that arrives while the 16-entry receive FIFO is full sets status bit 1 (overrun) in the next cycle. That character is discarded and the stored characters are kept unchanged.
- R3: Overrun stays set until a status-read strobe clears it. If a status read and a new overrun fall in the same cycle, the overrun stays set.
- R4: Status bits 2, 3 and 4 show the parity, framing and break flags of the character at the FIFO head. They read 0 when the FIFO is empty.
- R5: Status bit 7 is 1 while any stored character has at least one error flag. It returns to 0 by itself once all such characters have been popped.
- R6: Status bit 5 is 1 when the transmit occupancy input is 0. Status bit 6 is 1 only when the occupancy is 0 and the transmit shift register is idle.
- R7: The trigger selector codes 0, 1, 2 and 3 choose levels of 1, 4, 8 and 14. The trigger flag is 1 exactly when the FIFO enable is set and the FIFO count is at or above the chosen level.
- R8: The receive interrupt equals the trigger flag ANDed with interrupt enable bit 0. It rises when the count reaches the level and falls as soon as the count drops below it.
- R9: With all four interrupt enable bits at 0 (polled mode), the receive interrupt stays 0 while the status bits keep updating.
- R10: While reset is asserted, and right after it, the status byte reads 8'h60 whatever the transmit inputs are, and the receive FIFO is empty.
- R11: Characters leave the FIFO in arrival order. The head data output shows the oldest character. A read strobe on an empty FIFO has no effect.
- R12: The FIFO count never exceeds the depth. Sixteen pops after any overrun empty the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | FIFO mode enable; gates the trigger flag |
| int_en | input | 4 | Interrupt enable bits; bit 0 enables the receive interrupt |
| trig_sel | input | 2 | Trigger level selector |
| rx_push | input | 1 | Character strobe from the receive shift register |
| rx_data | input | 8 | Received data byte |
| rx_par_err | input | 1 | Parity error flag of the strobed character |
| rx_frm_err | input | 1 | Framing error flag of the strobed character |
| rx_brk | input | 1 | Break flag of the strobed character |
| host_rd | input | 1 | Pop the head character |
| lsr_rd | input | 1 | Status byte read acknowledge |
| tx_count | input | 5 | Transmit FIFO occupancy |
| tx_shift_idle | input | 1 | Transmit shift register is empty |
| rhr_data | output | 8 | Data byte at the receive FIFO head |
| lsr | output | 8 | Line status byte |
| rx_irq | output | 1 | Receive data interrupt |
| trig_hit | output | 1 | Trigger level reached flag |

## Verification
Every strobe acts at one rising edge, and the FIFO count, the head entry and the overrun flag are the only registers in the path. So bits 0, 1, 2 to 4 and 7, the head data, the trigger flag and the interrupt are all due one cycle after a push, pop or status read. Bits 5 and 6 depend only on the transmit inputs and follow them in the same cycle. The bench applies each strobe at a falling edge and removes it at the next falling edge, so exactly one rising edge falls inside the strobe. It compares all outputs at that second falling edge against a queue model that it updates at the same point.

// File: rtl/uart_lsr_pkg.sv
package uart_lsr_pkg;
   localparam int DW = 8;

   typedef struct packed {
      logic          brk;
      logic          frm;
      logic          par;
      logic [DW-1:0] data;
   } rx_ent_t;
endpackage

// File: rtl/uart_rx_store.sv
module uart_rx_store
   import uart_lsr_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          pop,
   input  rx_ent_t       din,
   output rx_ent_t       head,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          empty,
   output logic          err_any
);
   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2) begin : g_bad_depth
      $error("uart_rx_store: DEPTH must be a power of two of at least 2");
   end

   rx_ent_t              mem [DEPTH];
   logic [DEPTH-1:0]     vld;
   logic [DEPTH-1:0]     slot_err;
   logic [AW-1:0]        wp, rp;
   logic                 do_push, do_pop;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push & ~full;
   assign do_pop  = pop & ~empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
         vld   <= '0;
      end else begin
         if (do_push) begin
            wp      <= wp + 1'b1;
            vld[wp] <= 1'b1;
         end
         if (do_pop) begin
            rp      <= rp + 1'b1;
            vld[rp] <= 1'b0;
         end
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      assign slot_err[i] = vld[i] & (mem[i].brk | mem[i].frm | mem[i].par);
   end

   assign err_any = |slot_err;
   assign head    = mem[rp];
endmodule

// File: rtl/uart_trig_dec.sv
module uart_trig_dec #(
   parameter int DEPTH = 16,
   parameter int LVL0  = 1,
   parameter int LVL1  = 4,
   parameter int LVL2  = 8,
   parameter int LVL3  = 14,
   localparam int CW = $clog2(DEPTH) + 1
) (
   input  logic [1:0]    sel,
   input  logic [CW-1:0] count,
   output logic          reached
);
   if (LVL0 < 1 || LVL1 < 1 || LVL2 < 1 || LVL3 < 1 ||
       LVL0 > DEPTH || LVL1 > DEPTH || LVL2 > DEPTH || LVL3 > DEPTH) begin : g_bad_lvl
      $error("uart_trig_dec: trigger levels must lie in 1..DEPTH");
   end

   logic [CW-1:0] level;

   always_comb begin
      case (sel)
         2'd0:    level = CW'(LVL0);
         2'd1:    level = CW'(LVL1);
         2'd2:    level = CW'(LVL2);
         default: level = CW'(LVL3);
      endcase
   end

   assign reached = (count >= level);
endmodule

// File: rtl/uart_lsr_core.sv
module uart_lsr_core
   import uart_lsr_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int LVL0  = 1,
   parameter int LVL1  = 4,
   parameter int LVL2  = 8,
   parameter int LVL3  = 14,
   localparam int CW = $clog2(DEPTH) + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fifo_en,
   input  logic [3:0]    int_en,
   input  logic [1:0]    trig_sel,
   input  logic          rx_push,
   input  logic [DW-1:0] rx_data,
   input  logic          rx_par_err,
   input  logic          rx_frm_err,
   input  logic          rx_brk,
   input  logic          host_rd,
   input  logic          lsr_rd,
   input  logic [CW-1:0] tx_count,
   input  logic          tx_shift_idle,
   output logic [DW-1:0] rhr_data,
   output logic [7:0]    lsr,
   output logic          rx_irq,
   output logic          trig_hit
);
   rx_ent_t       wr_ent, hd_ent;
   logic [CW-1:0] rx_cnt;
   logic          rx_full, rx_empty, rx_err_any, lvl_reached, ovr;

   assign wr_ent = '{brk: rx_brk, frm: rx_frm_err, par: rx_par_err, data: rx_data};

   uart_rx_store #(.DEPTH(DEPTH)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (rx_push),
      .pop     (host_rd),
      .din     (wr_ent),
      .head    (hd_ent),
      .count   (rx_cnt),
      .full    (rx_full),
      .empty   (rx_empty),
      .err_any (rx_err_any)
   );

   uart_trig_dec #(.DEPTH(DEPTH), .LVL0(LVL0), .LVL1(LVL1), .LVL2(LVL2), .LVL3(LVL3)) u_trig (
      .sel     (trig_sel),
      .count   (rx_cnt),
      .reached (lvl_reached)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  ovr <= 1'b0;
      else if (rx_push && rx_full) ovr <= 1'b1;
      else if (lsr_rd)             ovr <= 1'b0;
   end

   logic tx_empty;
   assign tx_empty = (tx_count == '0) | ~rst_n;

   always_comb begin
      lsr    = '0;
      lsr[0] = ~rx_empty;
      lsr[1] = ovr;
      lsr[2] = ~rx_empty & hd_ent.par;
      lsr[3] = ~rx_empty & hd_ent.frm;
      lsr[4] = ~rx_empty & hd_ent.brk;
      lsr[5] = tx_empty;
      lsr[6] = tx_empty & (tx_shift_idle | ~rst_n);
      lsr[7] = rx_err_any;
   end

   assign rhr_data = hd_ent.data;
   assign trig_hit = fifo_en & lvl_reached;
   assign rx_irq   = trig_hit & int_en[0];
endmodule

// File: rtl/uart_lsr_chk.sv
module uart_lsr_chk #(
   parameter int DEPTH = 16,
   localparam int CW = $clog2(DEPTH) + 1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rx_push,
   input logic          host_rd,
   input logic          lsr_rd,
   input logic [3:0]    int_en,
   input logic [7:0]    lsr,
   input logic          rx_irq,
   input logic          trig_hit,
   input logic [CW-1:0] rx_cnt,
   input logic          rx_full
);
   assert_no_overflow_R12: assert property (@(posedge clk) disable iff (!rst_n)
      rx_cnt <= CW'(DEPTH));

   assert_ready_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_push && !host_rd) |=> lsr[0]);

   assert_ready_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_push && !host_rd) |=> $stable(lsr[0]));

   assert_overrun_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_push && rx_full) |=> lsr[1]);

   assert_overrun_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (lsr_rd && !(rx_push && rx_full)) |=> !lsr[1]);

   assert_overrun_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (lsr[1] && !lsr_rd) |=> lsr[1]);

   assert_tx_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
      lsr[6] |-> lsr[5]);

   assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |-> (trig_hit && int_en[0]));

   assert_polled_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (int_en == 4'b0000) |-> !rx_irq);

   assert_err_head_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (|lsr[4:2]) |-> lsr[7]);
endmodule

bind uart_lsr_core uart_lsr_chk #(.DEPTH(DEPTH)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rx_push  (rx_push),
   .host_rd  (host_rd),
   .lsr_rd   (lsr_rd),
   .int_en   (int_en),
   .lsr      (lsr),
   .rx_irq   (rx_irq),
   .trig_hit (trig_hit),
   .rx_cnt   (rx_cnt),
   .rx_full  (rx_full)
);

// File: tb/tb_uart_lsr_core.sv
module tb_uart_lsr_core;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fifo_en = 1'b1;
   logic [3:0] int_en = 4'b0001;
   logic [1:0] trig_sel = 2'd0;
   logic       rx_push = 1'b0;
   logic [7:0] rx_data = '0;
   logic       rx_par_err = 1'b0, rx_frm_err = 1'b0, rx_brk = 1'b0;
   logic       host_rd = 1'b0, lsr_rd = 1'b0;
   logic [4:0] tx_count = 5'd3;
   logic       tx_shift_idle = 1'b0;
   logic [7:0] rhr_data, lsr;
   logic       rx_irq, trig_hit;

   int n_cmp = 0, n_bad = 0;
   logic [10:0] mq [16];
   int   mcnt = 0;
   logic movr = 1'b0;

   always #5 clk = ~clk;

   uart_lsr_core dut (
      .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .int_en(int_en), .trig_sel(trig_sel),
      .rx_push(rx_push), .rx_data(rx_data), .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err),
      .rx_brk(rx_brk), .host_rd(host_rd), .lsr_rd(lsr_rd), .tx_count(tx_count),
      .tx_shift_idle(tx_shift_idle), .rhr_data(rhr_data), .lsr(lsr), .rx_irq(rx_irq),
      .trig_hit(trig_hit)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int lvl_of(input logic [1:0] s);
      case (s)
         2'd0: return 1;
         2'd1: return 4;
         2'd2: return 8;
         default: return 14;
      endcase
   endfunction

   task automatic check_all();
      logic any_err = 1'b0;
      logic [2:0] he = (mcnt > 0) ? mq[0][10:8] : 3'b000;
      logic exp_trig;
      for (int k = 0; k < mcnt; k++) any_err |= |mq[k][10:8];
      exp_trig = fifo_en && (mcnt >= lvl_of(trig_sel));
      chk("R1 data ready", int'(lsr[0]), int'(mcnt > 0));
      chk("R2/R3 overrun", int'(lsr[1]), int'(movr));
      chk("R4 head errors", int'(lsr[4:2]), int'(he));
      chk("R5 any error", int'(lsr[7]), int'(any_err));
      chk("R6 tx empty", int'(lsr[5]), int'(tx_count == 0));
      chk("R6 tx idle", int'(lsr[6]), int'(tx_count == 0 && tx_shift_idle));
      chk("R7 trigger", int'(trig_hit), int'(exp_trig));
      if (int_en == 4'b0000) chk("R9 polled irq", int'(rx_irq), 0);
      else                   chk("R8 irq", int'(rx_irq), int'(exp_trig && int_en[0]));
      if (mcnt > 0) chk("R11 head data", int'(rhr_data), int'(mq[0][7:0]));
   endtask

   // one strobe cycle: drive at negedge, model update, check at next negedge
   task automatic cyc(input logic psh, input logic [10:0] ent, input logic pop, input logic srd);
      logic was_full = (mcnt == 16);
      rx_push = psh; {rx_brk, rx_frm_err, rx_par_err, rx_data} = ent;
      host_rd = pop; lsr_rd = srd;
      @(negedge clk);
      rx_push = 1'b0; host_rd = 1'b0; lsr_rd = 1'b0;
      if (srd) movr = 1'b0;
      if (psh && was_full) movr = 1'b1;
      if (pop && mcnt > 0) begin
         for (int k = 0; k < 15; k++) mq[k] = mq[k+1];
         mcnt--;
      end
      if (psh && !was_full) begin
         mq[mcnt] = ent;
         mcnt++;
      end
      check_all();
   endtask

   initial begin
      #2_000_000;
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (2) @(negedge clk);
      chk("R10 reset status", int'(lsr), 8'h60);
      chk("R10 reset irq", int'(rx_irq), 0);
      rst_n = 1'b1;
      tx_count = 5'd0; tx_shift_idle = 1'b1;
      @(negedge clk);
      chk("R10 post reset status", int'(lsr), 8'h60);

      // R6 transmit sweep
      for (int t = 0; t < 3; t++)
         for (int i = 0; i < 2; i++) begin
            tx_count = 5'(t); tx_shift_idle = i[0];
            #1;
            chk("R6 tx empty", int'(lsr[5]), int'(t == 0));
            chk("R6 tx idle", int'(lsr[6]), int'(t == 0 && i == 1));
            @(negedge clk);
         end
      tx_count = 5'd0; tx_shift_idle = 1'b1;

      // R11 pop on empty has no effect
      cyc(1'b0, '0, 1'b1, 1'b0);

      for (int s = 0; s < 4; s++) begin
         trig_sel = 2'(s);
         case (s)
            0: begin int_en = 4'b0001; fifo_en = 1'b1; end
            1: begin int_en = 4'b0000; fifo_en = 1'b1; end // R9 polled
            2: begin int_en = 4'b1110; fifo_en = 1'b1; end
            default: begin int_en = 4'b0001; fifo_en = (s == 3); end
         endcase
         // fill 17 characters: last one overruns (R2), varied error tags
         for (int i = 0; i < 17; i++) begin
            logic [2:0] e = ((i + s) % 5 == 0) ? 3'(1 << ((i + s) % 3)) : 3'b000;
            cyc(1'b1, {e, 8'(i * 7 + s * 31)}, 1'b0, 1'b0);
         end
         // R3: status read clears overrun; with a colliding overrun it stays
         cyc(1'b1, 11'h0AA, 1'b0, 1'b1);
         cyc(1'b0, '0, 1'b0, 1'b1);
         if (s == 2) fifo_en = 1'b0;
         // drain all, checking head order, trigger fall and error summary
         for (int i = 0; i < 16; i++) cyc(1'b0, '0, 1'b1, 1'b0);
         chk("R12 drained after 16 pops", int'(lsr[0]), 0);
         fifo_en = 1'b1;
         // small trigger crossings both ways
         for (int i = 0; i < 5; i++) cyc(1'b1, {3'b100, 8'(i)}, 1'b0, 1'b0);
         for (int i = 0; i < 5; i++) cyc(1'b0, '0, 1'b1, 1'b0);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule